// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel of a timer. It runs either as an output compare or as an input capture. The counter itself is outside the block and arrives as an input word. In output mode, software writes a compare value through a simple write port. That value lands in a holding register. The block then compares the counter against an active register, which raises a match flag and drives a PWM-style output level.

When preload is switched off, a written value reaches the active register on the same edge as the write. When preload is on, the value waits in the holding register. It moves to the active register only when an update event pulse arrives. In input mode, the same holding register instead snapshots the counter on each capture pulse. Bus writes are then ignored, so software reads back the last captured count.

Top module: `cc_channel`

## Requirements
- R1: Reset (active low, asynchronous) clears the channel register (`chan_val`) and the active compare register (`active_val`) to zero.
- R2: In output mode (`in_mode`=0) with preload off (`preload_en`=0), a write updates both `chan_val` and `active_val` with `wr_data` at the clock edge where `wr_en` is high.
- R3: In output mode with preload on, a write without an update event updates `chan_val` only, and `active_val` keeps its value.
- R4: In output mode with preload on, an update event (`update`=1) with no write copies `chan_val` into `active_val` at that edge.
- R5: In output mode with preload on, when a write and an update event share a cycle, `active_val` takes the newly written `wr_data`.
- R6: In output mode, `match` is high exactly while `count` equals `active_val`. It is combinational and unsigned.
- R7: In output mode, `oc_level` is high exactly while `count` is below `active_val` (unsigned), and low otherwise. This includes the case `count`=`active_val`=0.
- R8: In input mode (`in_mode`=1), a capture pulse (`capture`=1) loads `count` into `chan_val` at that edge.
- R9: In input mode, writes and update events have no effect: `chan_val` holds unless a capture occurs, and `active_val` holds.
- R10: In input mode, `match` and `oc_level` are both held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the channel value |
| wr_data | input | WIDTH | Value to write |
| count | input | WIDTH | Free-running counter value |
| update | input | 1 | Update event pulse |
| capture | input | 1 | Capture event pulse |
| in_mode | input | 1 | 1 = input capture, 0 = output compare |
| preload_en | input | 1 | 1 = write waits for an update event |
| chan_val | output | WIDTH | Channel register (preload value or captured count) |
| active_val | output | WIDTH | Active compare value |
| match | output | 1 | Counter equals active compare value |
| oc_level | output | 1 | Compare output level |

## Verification
Stimulus that touches a register (`wr_en`, `update`, `capture`) shows up on `chan_val` and `active_val` one clock edge later. `match` and `oc_level` are combinational. They follow `count` in the same cycle and follow a change in `active_val` right after that edge. The bench drives every input on the falling edge and samples one time unit after the next rising edge. At that point the registered outputs already hold their new state, while the inputs are still those of the current vector. Each expected value is therefore the state after exactly one edge.

// File: rtl/cc_channel.sv
module cc_channel #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] count,
  input  logic             update,
  input  logic             capture,
  input  logic             in_mode,
  input  logic             preload_en,
  output logic [WIDTH-1:0] chan_val,
  output logic [WIDTH-1:0] active_val,
  output logic             match,
  output logic             oc_level
);

  logic out_wr, load_active;
  logic [WIDTH-1:0] active_nxt;

  assign out_wr      = !in_mode && wr_en;
  assign load_active = !in_mode && (preload_en ? update : wr_en);
  assign active_nxt  = wr_en ? wr_data : chan_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_val <= '0;
    end else if (in_mode) begin
      if (capture) chan_val <= count;
    end else if (out_wr) begin
      chan_val <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           active_val <= '0;
    else if (load_active) active_val <= active_nxt;
  end

  assign match    = !in_mode && (count == active_val);
  assign oc_level = !in_mode && (count <  active_val);

endmodule

module cc_channel_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] count,
  input logic             update,
  input logic             capture,
  input logic             in_mode,
  input logic             preload_en,
  input logic [WIDTH-1:0] chan_val,
  input logic [WIDTH-1:0] active_val,
  input logic             match,
  input logic             oc_level
);

  a_r2_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_mode && !preload_en && wr_en) |=> (active_val == $past(wr_data) && chan_val == $past(wr_data)));

  a_r3_preload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_mode && preload_en && wr_en && !update) |=> $stable(active_val));

  a_r4_update_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_mode && preload_en && update && !wr_en) |=> (active_val == $past(chan_val)));

  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_mode && preload_en && update && wr_en) |=> (active_val == $past(wr_data)));

  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode && capture) |=> (chan_val == $past(count)));

  a_r9_input_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode && !capture) |=> ($stable(chan_val) && $stable(active_val)));

  a_r10_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_mode |-> (!match && !oc_level));

  a_r6_match_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(match && oc_level));

endmodule

bind cc_channel cc_channel_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_cc_channel.sv
`timescale 1ns/1ps
module tb_cc_channel;

  localparam int W = 16;

  typedef struct packed {
    logic         im, pe, we;
    logic [W-1:0] wd;
    logic         up, cp;
    logic [W-1:0] cn, rd, ac;
    logic         mt, oc;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b1,16'd100, 1'b0,1'b0,16'd50,  16'd100, 16'd100,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,16'd0,   1'b0,1'b0,16'd100, 16'd100, 16'd100,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,16'd0,   1'b0,1'b0,16'd150, 16'd100, 16'd100,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,16'd200, 1'b0,1'b0,16'd150, 16'd200, 16'd100,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,16'd0,   1'b0,1'b0,16'd120, 16'd200, 16'd100,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,16'd0,   1'b1,1'b0,16'd120, 16'd200, 16'd200,1'b0,1'b1},
    '{1'b0,1'b1,1'b1,16'd300, 1'b1,1'b0,16'd300, 16'd300, 16'd300,1'b1,1'b0},
    '{1'b1,1'b0,1'b0,16'd0,   1'b0,1'b1,16'd1234,16'd1234,16'd300,1'b0,1'b0},
    '{1'b1,1'b0,1'b1,16'd999, 1'b0,1'b0,16'd5,   16'd1234,16'd300,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,16'd777, 1'b1,1'b0,16'd300, 16'd1234,16'd300,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,16'd0,   1'b0,1'b0,16'd300, 16'd1234,16'd300,1'b1,1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, update = 0, capture = 0, in_mode = 0, preload_en = 0;
  logic [W-1:0] wr_data = '0, count = '0;
  logic [W-1:0] chan_val, active_val;
  logic match, oc_level;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cc_channel #(.WIDTH(W)) dut (.*);

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic im, logic pe, logic we, logic [W-1:0] wd,
                       logic up, logic cp, logic [W-1:0] cn);
    @(negedge clk);
    in_mode = im; preload_en = pe; wr_en = we; wr_data = wd;
    update = up; capture = cp; count = cn;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 chan_val", chan_val, '0);
    chk("R1 active_val", active_val, '0);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].im, TBL[i].pe, TBL[i].we, TBL[i].wd, TBL[i].up, TBL[i].cp, TBL[i].cn);
      chk($sformatf("R2-9 vec%0d chan_val", i), chan_val, TBL[i].rd);
      chk($sformatf("R2-9 vec%0d active_val", i), active_val, TBL[i].ac);
      chk($sformatf("R6/R10 vec%0d match", i), W'(match), W'(TBL[i].mt));
      chk($sformatf("R7/R10 vec%0d oc_level", i), W'(oc_level), W'(TBL[i].oc));
    end

    // R7 boundary: full-scale compare value
    drive(0, 0, 1, 16'hFFFF, 0, 0, 16'hFFFE);
    chk("R2 full-scale active_val", active_val, 16'hFFFF);
    chk("R7 oc high below max", W'(oc_level), 1);
    drive(0, 0, 0, 0, 0, 0, 16'hFFFF);
    chk("R6 match at max", W'(match), 1);
    chk("R7 oc low at max", W'(oc_level), 0);

    // R1: reset mid-run
    @(negedge clk) rst_n = 0;
    #1;
    chk("R1 async chan_val", chan_val, '0);
    chk("R1 async active_val", active_val, '0);
    @(negedge clk) rst_n = 1;

    // R7 boundary: count 0 vs active 0
    drive(0, 0, 0, 0, 0, 0, 16'd0);
    chk("R6 match at zero", W'(match), 1);
    chk("R7 oc low at zero", W'(oc_level), 0);

    // R3/R4 preload held across cycles then update
    drive(0, 1, 1, 16'd42, 0, 0, 16'd10);
    drive(0, 1, 0, 16'd0, 0, 0, 16'd10);
    chk("R3 active held", active_val, 16'd0);
    drive(0, 1, 0, 16'd0, 1, 0, 16'd10);
    chk("R4 update copy", active_val, 16'd42);
    chk("R7 oc after update", W'(oc_level), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule